// File: doc/BRIEF.md
# Level-Sensed Interrupt Hold and Mask

This block watches a set of external interrupt request inputs: individual active-low request lines, and a multi-bit active-low bus that carries an encoded priority level. Each input is brought into the clock domain through a two-stage synchroniser. The block then decodes it into one source per line and one source per nonzero encoded level. A request seen on an unmasked source is captured in a hold latch. The latch keeps the request after the input goes away, so a short pulse is not lost before software services it.

Software owns a mask bit per source and reaches it through two write strobes that share one data word. One strobe sets mask bits and the other clears them, and a 1 in the data word selects a bit. Setting a mask bit is the only way to drop a held request. A source counts as released only after its synchronised input has stayed inactive for a qualification window. The service routine therefore masks the source and waits for the window to pass before unmasking, or the request is captured again. The mask register is always visible on an output, so software can read back a write.

The outputs are a pending vector (held and not masked) and a single request line that is high while any bit is pending. Arbitration, vector generation and acceptance handshakes belong to other blocks.

Top module: `level_irq_hold`

## Requirements
- R1: During and right after reset, every mask bit reads 1, the pending vector is all zero and int_req is 0.
- R2: Source bit i (0 to 3) follows request line irq_n[i], which is active low. Source bit 3+L follows encoded level L, where L is the bitwise inverse of irl_n. irl_n equal to 4'b1111 requests nothing.
- R3: A new request on an unmasked source appears in pending after the third rising edge that follows the input change.
- R4: A held request stays pending after its input goes inactive, however long the input stays inactive.
- R5: A write strobe on mask_set_we sets every mask bit whose data bit is 1 and clears the held request of those sources. Mask bits whose data bit is 0 keep their value.
- R6: A write strobe on mask_clr_we clears every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R7: When both strobes select the same bit in the same cycle, the bit ends up set.
- R8: A masked source never becomes pending, even while its input is active. Once unmasked with its input still active, it becomes pending one edge after the mask bit clears.
- R9: A deasserted input is treated as released only after its synchronised value has been inactive for 9 consecutive cycles. Suppose the mask-clear write lands on the Nth rising edge after the deassertion. The source is captured again if N is 10 or less, and stays clear if N is 11 or more.
- R10: int_req is 1 exactly when at least one pending bit is 1.
- R11: mask_q shows a write from the next edge on, and holds its value while neither strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 4 | Individual active-low request lines |
| irl_n | input | 4 | Active-low encoded request level |
| mask_set_we | input | 1 | Strobe: set the mask bits selected by mask_wdata |
| mask_clr_we | input | 1 | Strobe: clear the mask bits selected by mask_wdata |
| mask_wdata | input | 19 | Bit-select word for either strobe |
| mask_q | output | 19 | Current mask register |
| pending | output | 19 | Held requests that are not masked |
| int_req | output | 1 | OR of all pending bits |

## Verification
The hardest case to reach is the release window. A source must be masked and its input dropped, and then the unmask must land exactly on the last edge that still counts as active, or on the first edge past it. The stimulus starts from a known active state, releases the input right after an edge, and counts edges up to the clear strobe. One run lands on edge 10 and expects the request to be captured again; a second run lands on edge 11 and expects nothing. A table-driven pass covers every source kind and checks that the mask-wait-unmask sequence leaves nothing behind.

// File: rtl/ihm_pkg.sv
package ihm_pkg;

    localparam int unsigned IHM_N_IRQ    = 4;
    localparam int unsigned IHM_IRL_W    = 4;
    localparam int unsigned IHM_QUAL_CYC = 8;

    // Decoded mask-write command; set has priority over clear
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_CLR  = 2'b01,
        OP_SET  = 2'b10,
        OP_BOTH = 2'b11
    } mask_op_t;

    function automatic mask_op_t mask_op(input logic set_we, input logic clr_we);
        return mask_op_t'({set_we, clr_we});
    endfunction

    // Counter width able to hold the release threshold
    function automatic int unsigned rel_cnt_w(input int unsigned qual);
        return $clog2(qual + 2);
    endfunction

endpackage

// File: rtl/ihm_sync.sv
module ihm_sync #(
    parameter int unsigned    W       = 8,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/ihm_release_qual.sv
module ihm_release_qual
    import ihm_pkg::*;
#(
    parameter int unsigned N        = 19,
    parameter int unsigned QUAL_CYC = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] act,
    output logic [N-1:0] lvl
);
    localparam int unsigned      REL   = QUAL_CYC + 1;
    localparam int unsigned      CW    = rel_cnt_w(QUAL_CYC);
    localparam logic [CW-1:0]    REL_V = CW'(REL);

    for (genvar i = 0; i < N; i++) begin : g_src
        logic [CW-1:0] idle_cnt;

        always_ff @(posedge clk) begin
            if (rst) begin
                idle_cnt <= REL_V;
            end else if (act[i]) begin
                idle_cnt <= '0;
            end else if (idle_cnt != REL_V) begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end

        // Seen as requesting until the inactive run reaches the threshold
        assign lvl[i] = act[i] | (idle_cnt != REL_V);
    end
endmodule

// File: rtl/ihm_hold_mask.sv
module ihm_hold_mask
    import ihm_pkg::*;
#(
    parameter int unsigned N = 19
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask,
    output logic [N-1:0] held
);
    mask_op_t     op;
    logic [N-1:0] set_bits;
    logic [N-1:0] clr_bits;

    always_comb begin
        op       = mask_op(set_we, clr_we);
        set_bits = '0;
        clr_bits = '0;
        case (op)
            OP_SET,
            OP_BOTH: set_bits = wdata;
            OP_CLR:  clr_bits = wdata;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '1;
            held <= '0;
        end else begin
            mask <= (mask & ~clr_bits) | set_bits;
            held <= (held | (lvl & ~mask)) & ~set_bits;
        end
    end
endmodule

// File: rtl/level_irq_hold.sv
module level_irq_hold
    import ihm_pkg::*;
#(
    parameter int unsigned N_IRQ    = IHM_N_IRQ,
    parameter int unsigned IRL_W    = IHM_IRL_W,
    parameter int unsigned QUAL_CYC = IHM_QUAL_CYC,
    localparam int unsigned N_SRC   = N_IRQ + (1 << IRL_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] irq_n,
    input  logic [IRL_W-1:0] irl_n,
    input  logic             mask_set_we,
    input  logic             mask_clr_we,
    input  logic [N_SRC-1:0] mask_wdata,
    output logic [N_SRC-1:0] mask_q,
    output logic [N_SRC-1:0] pending,
    output logic             int_req
);
    localparam int unsigned N_LVL  = (1 << IRL_W) - 1;
    localparam int unsigned SYNC_W = N_IRQ + IRL_W;

    logic [SYNC_W-1:0] sync_n;
    logic [IRL_W-1:0]  irl_lvl;
    logic [N_SRC-1:0]  src_act;
    logic [N_SRC-1:0]  src_lvl;
    logic [N_SRC-1:0]  held;

    ihm_sync #(.W(SYNC_W), .RST_VAL({SYNC_W{1'b1}})) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({irl_n, irq_n}),
        .q   (sync_n)
    );

    assign irl_lvl = ~sync_n[SYNC_W-1 -: IRL_W];

    for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
        assign src_act[i] = ~sync_n[i];
    end

    for (genvar l = 1; l <= N_LVL; l++) begin : g_lvl
        assign src_act[N_IRQ + l - 1] = (irl_lvl == IRL_W'(l));
    end

    ihm_release_qual #(.N(N_SRC), .QUAL_CYC(QUAL_CYC)) u_qual (
        .clk (clk),
        .rst (rst),
        .act (src_act),
        .lvl (src_lvl)
    );

    ihm_hold_mask #(.N(N_SRC)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .lvl    (src_lvl),
        .set_we (mask_set_we),
        .clr_we (mask_clr_we),
        .wdata  (mask_wdata),
        .mask   (mask_q),
        .held   (held)
    );

    assign pending = held & ~mask_q;
    assign int_req = |pending;
endmodule

// File: rtl/ihm_checker.sv
module ihm_checker #(
    parameter int unsigned W = 19
) (
    input logic         clk,
    input logic         rst,
    input logic         set_we,
    input logic         clr_we,
    input logic [W-1:0] wdata,
    input logic [W-1:0] mask_q,
    input logic [W-1:0] pending,
    input logic         int_req
);
    p_reset_mask_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == {W{1'b1}} && pending == '0));

    p_set_mask_r5: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((mask_q & $past(wdata)) == $past(wdata)));

    p_set_drops_pend_r5: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((pending & $past(wdata)) == '0));

    p_clr_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((mask_q & $past(wdata)) == '0));

    p_no_rise_masked_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pending & ~$past(pending) & $past(mask_q)) == '0));

    p_req_needs_pend_r10: assert property (@(posedge clk) disable iff (rst)
        int_req |-> (pending != '0));

    p_mask_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(mask_q));
endmodule

bind level_irq_hold ihm_checker #(.W(N_SRC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .set_we  (mask_set_we),
    .clr_we  (mask_clr_we),
    .wdata   (mask_wdata),
    .mask_q  (mask_q),
    .pending (pending),
    .int_req (int_req)
);

// File: tb/level_irq_hold_tb.sv
`timescale 1ns/1ps
module level_irq_hold_tb;
    localparam int NS = 19;
    localparam logic [NS-1:0] ALL = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    irq_n = 4'hF;
    logic [3:0]    irl_n = 4'hF;
    logic          set_we = 1'b0;
    logic          clr_we = 1'b0;
    logic [NS-1:0] wdata = '0;
    logic [NS-1:0] mask_q;
    logic [NS-1:0] pending;
    logic          int_req;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    level_irq_hold u_dut (
        .clk         (clk),
        .rst         (rst),
        .irq_n       (irq_n),
        .irl_n       (irl_n),
        .mask_set_we (set_we),
        .mask_clr_we (clr_we),
        .mask_wdata  (wdata),
        .mask_q      (mask_q),
        .pending     (pending),
        .int_req     (int_req)
    );

    // {irq_n, irl_n, expected pending}
    localparam logic [26:0] VEC [7] = '{
        {4'b1110, 4'hF, 19'h00001},
        {4'b0111, 4'hF, 19'h00008},
        {4'b1010, 4'hF, 19'h00005},
        {4'b1111, 4'hE, 19'h00010},
        {4'b1111, 4'h0, 19'h40000},
        {4'b1111, 4'h5, 19'h02000},
        {4'b0000, 4'hA, 19'h0010F}
    };

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_set(input logic [NS-1:0] d);
        set_we = 1'b1; wdata = d;
        tick();
        set_we = 1'b0; wdata = '0;
    endtask

    task automatic wr_clr(input logic [NS-1:0] d);
        clr_we = 1'b1; wdata = d;
        tick();
        clr_we = 1'b0; wdata = '0;
    endtask

    initial begin
        #(5 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        chk(mask_q == ALL, "R1 mask reset", 32'(mask_q), 32'(ALL));
        chk(pending == '0 && int_req == 1'b0, "R1 pending reset", 32'(pending), 0);
        rst = 1'b0;
        tick();
        chk(mask_q == ALL && pending == '0, "R1 after release", 32'(mask_q), 32'(ALL));

        wr_clr(ALL);
        for (int v = 0; v < 7; v++) begin
            irq_n = VEC[v][26:23];
            irl_n = VEC[v][22:19];
            tick(2);
            chk(pending == '0, "R3 not before third edge", 32'(pending), 0);
            tick();
            chk(pending == VEC[v][18:0], "R2 R3 source map", 32'(pending), 32'(VEC[v][18:0]));
            chk(int_req == 1'b1, "R10 request high", 32'(int_req), 1);
            wr_set(ALL);
            irq_n = 4'hF; irl_n = 4'hF;
            tick(12);
            wr_clr(ALL);
            tick(2);
            chk(pending == '0 && int_req == 1'b0, "R5 no recapture after window",
                32'(pending), 0);
        end

        // R4: latch persists after release
        irq_n[1] = 1'b0;
        tick(3);
        irq_n[1] = 1'b1;
        tick(20);
        chk(pending == 19'h00002, "R4 held after release", 32'(pending), 32'h2);

        // R5: set selected bit only, drops the held request
        wr_set(19'h00002);
        chk(mask_q == 19'h00002, "R5 R11 set only selected", 32'(mask_q), 32'h2);
        chk(pending == '0 && int_req == 1'b0, "R5 pending dropped", 32'(pending), 0);
        tick(4);
        chk(mask_q == 19'h00002, "R11 mask stable", 32'(mask_q), 32'h2);
        wr_clr(19'h00002);
        tick(2);
        chk(pending == '0, "R5 held cleared by set", 32'(pending), 0);

        // R6: clear selected bit only
        wr_set(ALL);
        wr_clr(19'h00010);
        chk(mask_q == 19'h7FFEF, "R6 clear only selected", 32'(mask_q), 32'h7FFEF);

        // R7: both strobes together, set wins
        set_we = 1'b1; clr_we = 1'b1; wdata = 19'h00010;
        tick();
        set_we = 1'b0; clr_we = 1'b0; wdata = '0;
        chk(mask_q == ALL, "R7 set wins", 32'(mask_q), 32'(ALL));

        // R8: masked source does not latch
        irq_n[2] = 1'b0;
        tick(6);
        chk(pending == '0 && int_req == 1'b0, "R8 masked no latch", 32'(pending), 0);
        wr_clr(19'h00004);
        chk(pending == '0, "R8 not yet at unmask edge", 32'(pending), 0);
        tick();
        chk(pending == 19'h00004, "R8 latch after unmask", 32'(pending), 32'h4);
        wr_set(19'h00004);
        tick(5);
        chk(pending == '0, "R8 remasked active input", 32'(pending), 0);

        // R9: boundary N=10 recaptures
        irq_n[2] = 1'b1;
        tick(9);
        wr_clr(19'h00004);
        tick(2);
        chk(pending == 19'h00004, "R9 unmask at edge 10", 32'(pending), 32'h4);
        wr_set(19'h00004);
        irq_n[2] = 1'b0;
        tick(3);
        // R9: boundary N=11 stays clear
        irq_n[2] = 1'b1;
        tick(10);
        wr_clr(19'h00004);
        tick(3);
        chk(pending == '0 && int_req == 1'b0, "R9 unmask at edge 11", 32'(pending), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule